// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Unit

This block is the hazard controller of a five-stage in-order pipeline (fetch, decode/register read, execute, memory, writeback) with a register file of `NUM_REGS` registers. Each cycle it looks at the source register numbers of the instruction in decode. It also looks at the destination registers of the instructions in execute, memory and writeback. From these it chooses, for each of the two operands, whether the register-file value or a value bypassed from a later stage is used. The block is purely combinational, so its decisions apply in the same cycle as the inputs that cause them.

It also decides whether the pipeline runs normally, holds, or flushes. A hold is needed when a load in execute produces a register that the decode instruction reads. In that case the PC and the fetch/decode buffer keep their contents and a NOOP is placed into the decode/execute buffer. A flush happens when execute resolves a branch as taken. Branches are predicted not taken, so the two younger instructions are wrong-path. On the next clock edge the fetch and decode slots are loaded with NOOPs through multiplexers. No asynchronous clear is used. The decision is carried as an enumerated action, RUN, HOLD or FLUSH. FLUSH has the highest priority, then HOLD, and RUN applies otherwise. The action is recomputed every cycle, with no stored state.

Top module: `hz_unit`

## Requirements
- R1: With no producers writing (all write-enables low) and no taken branch, both forward selects are 00, and stall, bubble_ex, flush_if and flush_id are all 0.
- R2: Forward select encoding is 00 = register file, 01 = execute stage, 10 = memory stage, 11 = writeback stage. An operand whose used flag is high and whose register equals a writing execute-stage destination selects 01.
- R3: An operand that matches only a writing memory-stage destination selects 10. An operand that matches only a writing writeback-stage destination selects 11.
- R4: When several stages write the operand's register, the youngest stage wins: execute over memory over writeback. No stall results from this alone.
- R5: Register 0 never causes forwarding or a stall, whether it appears as the source or as the destination.
- R6: A stage whose write-enable is low is never a forwarding or stall candidate, even if its destination field matches.
- R7: A source whose used flag is low selects 00 and cannot cause a stall.
- R8: A load in execute whose nonzero destination matches a used source in decode raises stall and bubble_ex for that cycle, with both flushes low.
- R9: A load that has reached the memory stage causes no stall. A matching operand forwards from it with select 10.
- R10: A taken branch in execute raises flush_if and flush_id, with stall and bubble_ex low.
- R11: A taken branch coinciding with a load-use hazard yields FLUSH: both flushes high, stall and bubble_ex low.
- R12: Operands A and B are resolved independently. Each gets its own select from its own register number and used flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | RA_W | Register number of operand A in decode |
| id_src_a_used | input | 1 | Operand A field is a real source |
| id_src_b | input | RA_W | Register number of operand B in decode |
| id_src_b_used | input | 1 | Operand B field is a real source |
| ex_dst | input | RA_W | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | RA_W | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | RA_W | Destination register of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| ex_branch_taken | input | 1 | Execute resolved a branch as taken |
| fwd_sel_a | output | 2 | Operand A source select |
| fwd_sel_b | output | 2 | Operand B source select |
| stall | output | 1 | Hold PC and fetch/decode buffer |
| bubble_ex | output | 1 | Load a NOOP into the decode/execute buffer |
| flush_if | output | 1 | Replace the fetch-slot instruction with a NOOP |
| flush_id | output | 1 | Replace the decode-slot instruction with a NOOP |

## Verification
The bench drives a write-after-write stack with all three stages writing one register. A unit with the wrong priority would return 10 or 11 instead of 01. It also drives register 0 as a loaded destination and as a source; a design that forgets to exclude it would forward stale data or stall needlessly. Store-like decode instructions are given unused fields and producers are given a cleared write-enable; both must not match, or the unit would stall when it should not. Finally, a taken branch is raised at the same time as a load-use hazard. A design with the wrong precedence would hold the wrong-path instruction instead of flushing it.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_EX  = 2'b01,
        FWD_MEM = 2'b10,
        FWD_WB  = 2'b11
    } fwd_sel_e;

    typedef enum logic [1:0] {
        ACT_RUN   = 2'd0,
        ACT_HOLD  = 2'd1,
        ACT_FLUSH = 2'd2
    } pipe_act_e;

    localparam int unsigned N_PROD = 3;  // producers: 0 = EX, 1 = MEM, 2 = WB

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int unsigned RA_W = 4
) (
    input  logic [RA_W-1:0] src,
    input  logic            src_used,
    input  logic [RA_W-1:0] prod_dst [N_PROD],
    input  logic            prod_wen [N_PROD],
    output fwd_sel_e        sel
);

    logic [N_PROD-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N_PROD; g++) begin : g_cmp
            assign hit[g] = src_used && prod_wen[g]
                            && (prod_dst[g] != '0) && (prod_dst[g] == src);
        end
    endgenerate

    // youngest producer (index 0) takes priority
    always_comb begin
        sel = FWD_RF;
        if (hit[2]) sel = FWD_WB;
        if (hit[1]) sel = FWD_MEM;
        if (hit[0]) sel = FWD_EX;
    end

endmodule

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
    parameter int unsigned RA_W = 4
) (
    input  logic [RA_W-1:0] src_a,
    input  logic            src_a_used,
    input  logic [RA_W-1:0] src_b,
    input  logic            src_b_used,
    input  logic [RA_W-1:0] ld_dst,
    input  logic            ld_wen,
    input  logic            ld_is_load,
    output logic            hazard
);

    logic ld_live;
    logic a_hit;
    logic b_hit;

    assign ld_live = ld_wen && ld_is_load && (ld_dst != '0);
    assign a_hit   = src_a_used && (src_a == ld_dst);
    assign b_hit   = src_b_used && (src_b == ld_dst);
    assign hazard  = ld_live && (a_hit || b_hit);

endmodule

// File: rtl/hz_ctrl_decide.sv
module hz_ctrl_decide
    import hz_pkg::*;
(
    input  logic      load_use,
    input  logic      branch_taken,
    output pipe_act_e act,
    output logic      stall,
    output logic      bubble_ex,
    output logic      flush_if,
    output logic      flush_id
);

    // action selection: flush outranks hold
    always_comb begin
        if (branch_taken)  act = ACT_FLUSH;
        else if (load_use) act = ACT_HOLD;
        else               act = ACT_RUN;
    end

    // output decode per action
    always_comb begin
        stall     = 1'b0;
        bubble_ex = 1'b0;
        flush_if  = 1'b0;
        flush_id  = 1'b0;
        unique case (act)
            ACT_RUN: begin
            end
            ACT_HOLD: begin
                stall     = 1'b1;
                bubble_ex = 1'b1;
            end
            ACT_FLUSH: begin
                flush_if = 1'b1;
                flush_id = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    localparam int unsigned RA_W    = $clog2(NUM_REGS)
) (
    input  logic [RA_W-1:0] id_src_a,
    input  logic            id_src_a_used,
    input  logic [RA_W-1:0] id_src_b,
    input  logic            id_src_b_used,
    input  logic [RA_W-1:0] ex_dst,
    input  logic            ex_wen,
    input  logic            ex_is_load,
    input  logic [RA_W-1:0] mem_dst,
    input  logic            mem_wen,
    input  logic [RA_W-1:0] wb_dst,
    input  logic            wb_wen,
    input  logic            ex_branch_taken,
    output logic [1:0]      fwd_sel_a,
    output logic [1:0]      fwd_sel_b,
    output logic            stall,
    output logic            bubble_ex,
    output logic            flush_if,
    output logic            flush_id
);

    logic [RA_W-1:0] prod_dst [N_PROD];
    logic            prod_wen [N_PROD];
    logic [RA_W-1:0] op_src   [2];
    logic            op_used  [2];
    fwd_sel_e        op_sel   [2];
    logic            load_use;
    pipe_act_e       act;

    assign prod_dst[0] = ex_dst;
    assign prod_dst[1] = mem_dst;
    assign prod_dst[2] = wb_dst;
    assign prod_wen[0] = ex_wen;
    assign prod_wen[1] = mem_wen;
    assign prod_wen[2] = wb_wen;

    assign op_src[0]  = id_src_a;
    assign op_src[1]  = id_src_b;
    assign op_used[0] = id_src_a_used;
    assign op_used[1] = id_src_b_used;

    genvar k;
    generate
        for (k = 0; k < 2; k++) begin : g_op
            hz_fwd_pick #(.RA_W(RA_W)) u_pick (
                .src      (op_src[k]),
                .src_used (op_used[k]),
                .prod_dst (prod_dst),
                .prod_wen (prod_wen),
                .sel      (op_sel[k])
            );
        end
    endgenerate

    assign fwd_sel_a = op_sel[0];
    assign fwd_sel_b = op_sel[1];

    hz_loaduse_detect #(.RA_W(RA_W)) u_lu (
        .src_a      (id_src_a),
        .src_a_used (id_src_a_used),
        .src_b      (id_src_b),
        .src_b_used (id_src_b_used),
        .ld_dst     (ex_dst),
        .ld_wen     (ex_wen),
        .ld_is_load (ex_is_load),
        .hazard     (load_use)
    );

    hz_ctrl_decide u_dec (
        .load_use     (load_use),
        .branch_taken (ex_branch_taken),
        .act          (act),
        .stall        (stall),
        .bubble_ex    (bubble_ex),
        .flush_if     (flush_if),
        .flush_id     (flush_id)
    );

    // checks across the picker, detector and decider
    always_comb begin
        AST_STALL_NEEDS_LOAD: assert (!stall || (ex_is_load && ex_wen && ex_dst != '0)); // R8
        AST_NO_FWD_ZERO_A: assert (fwd_sel_a == FWD_RF || id_src_a != '0); // R5
        AST_NO_FWD_ZERO_B: assert (fwd_sel_b == FWD_RF || id_src_b != '0); // R5
        AST_UNUSED_A_RF: assert (id_src_a_used || fwd_sel_a == FWD_RF); // R7
        AST_UNUSED_B_RF: assert (id_src_b_used || fwd_sel_b == FWD_RF); // R7
        AST_EX_SEL_MATCH: assert (fwd_sel_a != FWD_EX || (ex_wen && ex_dst == id_src_a)); // R2
        AST_STALL_SEES_EX: assert (!stall || fwd_sel_a == FWD_EX || fwd_sel_b == FWD_EX); // R8
        AST_BRANCH_WINS: assert (!ex_branch_taken || (flush_if && flush_id && !stall && !bubble_ex)); // R11
    end

endmodule

// File: tb/hz_unit_tb.sv
module hz_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [3:0] id_src_a, id_src_b, ex_dst, mem_dst, wb_dst;
    logic       id_src_a_used, id_src_b_used, ex_wen, ex_is_load;
    logic       mem_wen, wb_wen, ex_branch_taken;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic       stall, bubble_ex, flush_if, flush_id;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    hz_unit dut_i (
        .id_src_a(id_src_a), .id_src_a_used(id_src_a_used),
        .id_src_b(id_src_b), .id_src_b_used(id_src_b_used),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen),
        .wb_dst(wb_dst), .wb_wen(wb_wen),
        .ex_branch_taken(ex_branch_taken),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .stall(stall), .bubble_ex(bubble_ex),
        .flush_if(flush_if), .flush_id(flush_id)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // packed control view: {stall, bubble_ex, flush_if, flush_id}
    function automatic logic [3:0] ctl();
        return {stall, bubble_ex, flush_if, flush_id};
    endfunction

    task automatic idle();
        id_src_a = 4'd0; id_src_a_used = 1'b0;
        id_src_b = 4'd0; id_src_b_used = 1'b0;
        ex_dst = 4'd0; ex_wen = 1'b0; ex_is_load = 1'b0;
        mem_dst = 4'd0; mem_wen = 1'b0;
        wb_dst = 4'd0; wb_wen = 1'b0;
        ex_branch_taken = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_idle();
        @(posedge clk); idle(); settle();
        chk("R1 sel_a", fwd_sel_a, 2'b00);
        chk("R1 sel_b", fwd_sel_b, 2'b00);
        chk("R1 ctl", ctl(), 4'b0000);
    endtask

    task automatic t_single_stage();
        @(posedge clk); idle();
        id_src_a = 4'd5; id_src_a_used = 1'b1;
        ex_dst = 4'd5; ex_wen = 1'b1; settle();
        chk("R2 ex fwd", fwd_sel_a, 2'b01);
        chk("R2 no stall on alu", ctl(), 4'b0000);
        @(posedge clk); idle();
        id_src_a = 4'd6; id_src_a_used = 1'b1;
        mem_dst = 4'd6; mem_wen = 1'b1; settle();
        chk("R3 mem fwd", fwd_sel_a, 2'b10);
        @(posedge clk); idle();
        id_src_b = 4'd7; id_src_b_used = 1'b1;
        wb_dst = 4'd7; wb_wen = 1'b1; settle();
        chk("R3 wb fwd", fwd_sel_b, 2'b11);
    endtask

    task automatic t_waw();
        @(posedge clk); idle();
        id_src_a = 4'd9; id_src_a_used = 1'b1;
        ex_dst = 4'd9; ex_wen = 1'b1;
        mem_dst = 4'd9; mem_wen = 1'b1;
        wb_dst = 4'd9; wb_wen = 1'b1; settle();
        chk("R4 ex wins", fwd_sel_a, 2'b01);
        chk("R4 no stall", ctl(), 4'b0000);
        @(posedge clk); ex_wen = 1'b0; settle();
        chk("R4 mem over wb", fwd_sel_a, 2'b10);
    endtask

    task automatic t_zero_reg();
        @(posedge clk); idle();
        id_src_a = 4'd0; id_src_a_used = 1'b1;
        id_src_b = 4'd0; id_src_b_used = 1'b1;
        ex_dst = 4'd0; ex_wen = 1'b1; ex_is_load = 1'b1;
        mem_dst = 4'd0; mem_wen = 1'b1;
        wb_dst = 4'd0; wb_wen = 1'b1; settle();
        chk("R5 sel_a", fwd_sel_a, 2'b00);
        chk("R5 sel_b", fwd_sel_b, 2'b00);
        chk("R5 no stall", ctl(), 4'b0000);
    endtask

    task automatic t_wen_low();
        @(posedge clk); idle();
        id_src_a = 4'd3; id_src_a_used = 1'b1;
        ex_dst = 4'd3; ex_is_load = 1'b1;
        mem_dst = 4'd3; wb_dst = 4'd3; settle();
        chk("R6 sel_a", fwd_sel_a, 2'b00);
        chk("R6 no stall", ctl(), 4'b0000);
    endtask

    task automatic t_unused();
        @(posedge clk); idle();
        id_src_a = 4'd4; id_src_b = 4'd4;
        ex_dst = 4'd4; ex_wen = 1'b1; ex_is_load = 1'b1; settle();
        chk("R7 sel_a", fwd_sel_a, 2'b00);
        chk("R7 sel_b", fwd_sel_b, 2'b00);
        chk("R7 no stall", ctl(), 4'b0000);
    endtask

    task automatic t_load_use();
        @(posedge clk); idle();
        id_src_b = 4'd8; id_src_b_used = 1'b1;
        id_src_a = 4'd2; id_src_a_used = 1'b1;
        ex_dst = 4'd8; ex_wen = 1'b1; ex_is_load = 1'b1; settle();
        chk("R8 ctl", ctl(), 4'b1100);
        // next cycle the load has moved to MEM, bubble in EX
        @(posedge clk); idle();
        id_src_b = 4'd8; id_src_b_used = 1'b1;
        id_src_a = 4'd2; id_src_a_used = 1'b1;
        mem_dst = 4'd8; mem_wen = 1'b1; settle();
        chk("R9 ctl", ctl(), 4'b0000);
        chk("R9 sel_b", fwd_sel_b, 2'b10);
        chk("R12 sel_a", fwd_sel_a, 2'b00);
    endtask

    task automatic t_branch();
        @(posedge clk); idle();
        ex_branch_taken = 1'b1; settle();
        chk("R10 ctl", ctl(), 4'b0011);
        @(posedge clk); idle();
        id_src_a = 4'd11; id_src_a_used = 1'b1;
        ex_dst = 4'd11; ex_wen = 1'b1; ex_is_load = 1'b1;
        ex_branch_taken = 1'b1; settle();
        chk("R11 ctl", ctl(), 4'b0011);
    endtask

    task automatic t_independent();
        @(posedge clk); idle();
        id_src_a = 4'd12; id_src_a_used = 1'b1;
        id_src_b = 4'd13; id_src_b_used = 1'b1;
        ex_dst = 4'd13; ex_wen = 1'b1;
        wb_dst = 4'd12; wb_wen = 1'b1; settle();
        chk("R12 sel_a", fwd_sel_a, 2'b11);
        chk("R12 sel_b", fwd_sel_b, 2'b01);
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_single_stage();
        t_waw();
        t_zero_reg();
        t_wen_low();
        t_unused();
        t_load_use();
        t_branch();
        t_independent();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule